// File: doc/BRIEF.md
# Boot-Sector Map and Write-Permission Guard

This block sits beside the command logic of a word-addressed flash array. It turns a word address into a sector number and a protection-group number. The array is split into eight small 4K-word boot sectors and 127 large 32K-word main sectors, 4M words in all. A parameter places the eight boot sectors either in the highest 32K words or in the lowest 32K words of the address space.

For every program or erase request the block decides in the same cycle whether the target may be written. The caller can therefore abandon a refused request before any operation starts. Three separate things can refuse a request:

- Stored per-group protection bits. These are set one group at a time, cleared all at once by a chip-wide unprotect strobe, and bypassed without being lost while a temporary-unprotect level is held.
- A write-protect pin. While it is held low, the two boot sectors at the far end of the array are refused.
- A one-time lock on a separate 128-word secured region. Once the lock is set, it cannot be undone.

Top module: `flash_boot_guard`

## Requirements
- R1: With boot sectors at the bottom (BOOT_TOP=0), word addresses 0..32767 map to sectors 0..7, each 4096 words wide, in ascending order. Every higher address maps to sector 7 + (address / 32768).
- R2: With boot sectors at the top (BOOT_TOP=1, the default), address / 32768 gives the sector for addresses below 127*32768. The top 32768 words map to sectors 127..134, each 4096 words wide.
- R3: Main sectors are grouped four at a time, and each boot sector is a group of its own. With boot at the top, main groups come first: main groups are 0..31 and boot groups are 32..39. With boot at the bottom, boot groups come first: boot groups are 0..7 and main groups are 8..39. A one-cycle prot_set pulse protects the group of req_addr from the next cycle on. A request made in the same cycle as the pulse is judged on the old state.
- R4: While wp_n is low, array requests to the two outermost boot sectors are refused whatever the group bits or unprot_temp say. These are sectors 133 and 134 with boot at the top, and sectors 0 and 1 with boot at the bottom. Other boot sectors are not affected by wp_n.
- R5: A request with req_sec high targets the secured region. It is refused if and only if the lock is set. A sec_lock pulse sets the lock from the next cycle on. Only reset returns the lock to its preload value SEC_LOCK_INIT (default 0). The lock has no effect on array requests.
- R6: An unprot_all pulse clears every group bit from the next cycle on. It wins over a prot_set pulse in the same cycle. It leaves the lock unchanged.
- R7: While unprot_temp is high, group bits do not refuse requests. The stored bits are kept, so protection returns when unprot_temp falls. unprot_temp does not bypass the lock.
- R8: req_ok is 1 only while req_valid is high and the request is permitted. The result is combinational and appears in the same cycle. After reset, no group is protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A program or erase request is presented |
| req_sec | input | 1 | Request targets the secured region instead of the array |
| req_addr | input | ADDR_W | Word address of the request, or of the group for prot_set |
| prot_set | input | 1 | Protect the group containing req_addr |
| unprot_all | input | 1 | Clear all group protection |
| unprot_temp | input | 1 | Level: bypass group protection |
| wp_n | input | 1 | Write-protect pin, active low |
| sec_lock | input | 1 | Permanently lock the secured region |
| req_ok | output | 1 | Request permitted |
| sect_idx | output | SECT_W | Sector of req_addr |
| grp_idx | output | GRP_W | Protection group of req_addr |

## Verification
Two functions can fall in the same cycle. A protect pulse for a group can coincide with a request to that group. The bench presents both at once and expects the request to be allowed in that cycle and refused in the following one. It then issues a protect pulse together with the chip-wide clear, and expects the clear to win: the group named by the pulse must remain writable afterwards. Both boot placements are instantiated, so each address map and its write-protect corners are judged against expected values that the bench computes with its own arithmetic.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int DEF_ADDR_W  = 22;  // 4M words
  localparam int DEF_MAIN_AW = 15;  // 32K-word main sector
  localparam int DEF_BOOT_AW = 12;  // 4K-word boot sector
  localparam int DEF_GRP_SH  = 2;   // four main sectors per group

  typedef enum logic {
    TGT_ARRAY  = 1'b0,
    TGT_SECURE = 1'b1
  } guard_tgt_e;
endpackage

// File: rtl/fbg_rst_sync.sv
module fbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fbg_sect_map.sv
module fbg_sect_map #(
  parameter int ADDR_W   = 22,
  parameter int MAIN_AW  = 15,
  parameter int BOOT_AW  = 12,
  parameter bit BOOT_TOP = 1'b1,
  parameter int GRP_SH   = 2,
  parameter int SECT_W   = 8,
  parameter int GRP_W    = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SECT_W-1:0] sect,
  output logic [GRP_W-1:0]  grp,
  output logic              outer
);
  localparam int UP_W     = ADDR_W - MAIN_AW;
  localparam int SUB_W    = MAIN_AW - BOOT_AW;
  localparam int NUM_BOOT = 1 << SUB_W;
  localparam int NUM_MAIN = (1 << UP_W) - 1;
  localparam int NUM_MGRP = (NUM_MAIN + (1 << GRP_SH) - 1) >> GRP_SH;

  logic [UP_W-1:0]  upper;
  logic [SUB_W-1:0] sub;
  logic             in_boot;

  assign upper = addr[ADDR_W-1:MAIN_AW];
  assign sub   = addr[MAIN_AW-1:BOOT_AW];

  generate
    if (BOOT_TOP) begin : g_top
      always_comb begin
        in_boot = &upper;
        if (in_boot) begin
          sect = SECT_W'(NUM_MAIN) + SECT_W'(sub);
          grp  = GRP_W'(NUM_MGRP) + GRP_W'(sub);
        end else begin
          sect = SECT_W'(upper);
          grp  = GRP_W'(upper >> GRP_SH);
        end
        outer = in_boot && (sub >= SUB_W'(NUM_BOOT - 2));
      end
    end else begin : g_bot
      logic [UP_W-1:0] main_i;
      always_comb begin
        in_boot = ~|upper;
        main_i  = upper - UP_W'(1);
        if (in_boot) begin
          sect = SECT_W'(sub);
          grp  = GRP_W'(sub);
        end else begin
          sect = SECT_W'(NUM_BOOT) + SECT_W'(main_i);
          grp  = GRP_W'(NUM_BOOT) + GRP_W'(main_i >> GRP_SH);
        end
        outer = in_boot && (sub < SUB_W'(2));
      end
    end
  endgenerate
endmodule

// File: rtl/fbg_prot_regs.sv
module fbg_prot_regs #(
  parameter int NUM_GRP       = 40,
  parameter int GRP_W         = 6,
  parameter bit SEC_LOCK_INIT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [GRP_W-1:0]   set_grp,
  input  logic               clr_all,
  input  logic               lock_en,
  output logic [NUM_GRP-1:0] grp_q,
  output logic               lock_q
);
  logic [NUM_GRP-1:0] grp_d;
  logic               grp_we;
  logic               lock_d;

  always_comb begin
    grp_we = clr_all | set_en;
    grp_d  = grp_q;
    if (clr_all)     grp_d = '0;
    else if (set_en) grp_d[set_grp] = 1'b1;
    lock_d = lock_q | lock_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (grp_we) grp_q <= grp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= SEC_LOCK_INIT;
    else if (lock_en) lock_q <= lock_d;
  end

  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_unprot_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (grp_q == '0));
  p_set_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_all) |=> grp_q[$past(set_grp)]);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_all) |=> $stable(grp_q));
endmodule

// File: rtl/flash_boot_guard.sv
module flash_boot_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W        = DEF_ADDR_W,
  parameter int MAIN_AW       = DEF_MAIN_AW,
  parameter int BOOT_AW       = DEF_BOOT_AW,
  parameter int GRP_SH        = DEF_GRP_SH,
  parameter bit BOOT_TOP      = 1'b1,
  parameter bit SEC_LOCK_INIT = 1'b0,
  localparam int NUM_BOOT = 1 << (MAIN_AW - BOOT_AW),
  localparam int NUM_MAIN = (1 << (ADDR_W - MAIN_AW)) - 1,
  localparam int NUM_SECT = NUM_BOOT + NUM_MAIN,
  localparam int NUM_GRP  = NUM_BOOT + ((NUM_MAIN + (1 << GRP_SH) - 1) >> GRP_SH),
  localparam int SECT_W   = $clog2(NUM_SECT),
  localparam int GRP_W    = $clog2(NUM_GRP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              prot_set,
  input  logic              unprot_all,
  input  logic              unprot_temp,
  input  logic              wp_n,
  input  logic              sec_lock,
  output logic              req_ok,
  output logic [SECT_W-1:0] sect_idx,
  output logic [GRP_W-1:0]  grp_idx
);
  logic               rst_n_s;
  logic               map_outer;
  logic [NUM_GRP-1:0] grp_q;
  logic               lock_q;
  logic               deny;
  guard_tgt_e         tgt;

  fbg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  fbg_sect_map #(
    .ADDR_W   (ADDR_W),
    .MAIN_AW  (MAIN_AW),
    .BOOT_AW  (BOOT_AW),
    .BOOT_TOP (BOOT_TOP),
    .GRP_SH   (GRP_SH),
    .SECT_W   (SECT_W),
    .GRP_W    (GRP_W)
  ) u_map (
    .addr  (req_addr),
    .sect  (sect_idx),
    .grp   (grp_idx),
    .outer (map_outer)
  );

  fbg_prot_regs #(
    .NUM_GRP       (NUM_GRP),
    .GRP_W         (GRP_W),
    .SEC_LOCK_INIT (SEC_LOCK_INIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_en  (prot_set),
    .set_grp (grp_idx),
    .clr_all (unprot_all),
    .lock_en (sec_lock),
    .grp_q   (grp_q),
    .lock_q  (lock_q)
  );

  always_comb begin
    tgt = req_sec ? TGT_SECURE : TGT_ARRAY;
    if (tgt == TGT_SECURE) deny = lock_q;
    else deny = (grp_q[grp_idx] & ~unprot_temp) | (map_outer & ~wp_n);
    req_ok = req_valid & ~deny;
  end

  p_wp_outer_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && !req_sec && map_outer && !wp_n) |-> !req_ok);
  p_sec_locked_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_sec && lock_q) |-> !req_ok);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req_valid |-> !req_ok);
  p_sect_range_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sect_idx < SECT_W'(NUM_SECT)) && (grp_idx < GRP_W'(NUM_GRP)));
endmodule

// File: tb/flash_boot_guard_bench.sv
module flash_boot_guard_bench;
  localparam int TOP_BASE = 127 * 32768;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_sec = 1'b0;
  logic [21:0] req_addr = '0;
  logic        prot_set = 1'b0, unprot_all = 1'b0, unprot_temp = 1'b0;
  logic        wp_n = 1'b1, sec_lock = 1'b0;
  logic        ok_t, ok_b;
  logic [7:0]  sect_t, sect_b;
  logic [5:0]  grp_t, grp_b;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  flash_boot_guard u_flash_boot_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sec(req_sec),
    .req_addr(req_addr), .prot_set(prot_set), .unprot_all(unprot_all),
    .unprot_temp(unprot_temp), .wp_n(wp_n), .sec_lock(sec_lock),
    .req_ok(ok_t), .sect_idx(sect_t), .grp_idx(grp_t)
  );

  flash_boot_guard #(.BOOT_TOP(1'b0)) u_flash_boot_guard_bot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sec(req_sec),
    .req_addr(req_addr), .prot_set(prot_set), .unprot_all(unprot_all),
    .unprot_temp(unprot_temp), .wp_n(wp_n), .sec_lock(sec_lock),
    .req_ok(ok_b), .sect_idx(sect_b), .grp_idx(grp_b)
  );

  function automatic int exp_sect(int a, bit top);
    if (top) return (a >= TOP_BASE) ? 127 + (a - TOP_BASE) / 4096 : a / 32768;
    return (a < 32768) ? a / 4096 : 7 + a / 32768;
  endfunction

  function automatic int exp_grp(int a, bit top);
    if (top) return (a >= TOP_BASE) ? 32 + (a - TOP_BASE) / 4096 : (a / 32768) / 4;
    return (a < 32768) ? a / 4096 : 8 + (a / 32768 - 1) / 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample 2 ns later (before the next rising edge)
  task automatic drive(logic v, logic s, int a);
    @(negedge clk);
    req_valid = v; req_sec = s; req_addr = 22'(a);
    #2;
  endtask

  task automatic t_reset;
    drive(1'b0, 1'b0, 5 * 32768);
    chk("R8 idle", ok_t, 0);
    drive(1'b1, 1'b0, 5 * 32768);
    chk("R8 array after reset", ok_t, 1);
    drive(1'b1, 1'b1, 0);
    chk("R5 secured unlocked after reset", ok_t, 1);
  endtask

  task automatic t_map;
    int addrs[10] = '{0, 4095, 3 * 4096 + 1, 32768, 4 * 32768 + 7,
                      9 * 32768, TOP_BASE - 1, TOP_BASE, TOP_BASE + 6 * 4096 + 9,
                      4194303};
    foreach (addrs[i]) begin
      drive(1'b1, 1'b0, addrs[i]);
      chk("R2 top sector", sect_t, exp_sect(addrs[i], 1'b1));
      chk("R3 top group", grp_t, exp_grp(addrs[i], 1'b1));
      chk("R1 bottom sector", sect_b, exp_sect(addrs[i], 1'b0));
      chk("R3 bottom group", grp_b, exp_grp(addrs[i], 1'b0));
    end
  endtask

  task automatic t_wp;
    @(negedge clk); wp_n = 1'b0;
    drive(1'b1, 1'b0, TOP_BASE + 7 * 4096);
    chk("R4 top sector 134 refused", ok_t, 0);
    drive(1'b1, 1'b0, TOP_BASE + 6 * 4096);
    chk("R4 top sector 133 refused", ok_t, 0);
    drive(1'b1, 1'b0, TOP_BASE + 5 * 4096);
    chk("R4 top sector 132 allowed", ok_t, 1);
    drive(1'b1, 1'b0, 100);
    chk("R4 bottom sector 0 refused", ok_b, 0);
    drive(1'b1, 1'b0, 4096 + 5);
    chk("R4 bottom sector 1 refused", ok_b, 0);
    drive(1'b1, 1'b0, 8192);
    chk("R4 bottom sector 2 allowed", ok_b, 1);
    @(negedge clk); unprot_temp = 1'b1;
    drive(1'b1, 1'b0, TOP_BASE + 7 * 4096);
    chk("R4 temp unprotect does not bypass pin", ok_t, 0);
    @(negedge clk); unprot_temp = 1'b0; wp_n = 1'b1;
    drive(1'b1, 1'b0, TOP_BASE + 7 * 4096);
    chk("R4 pin released", ok_t, 1);
  endtask

  task automatic t_protect;
    @(negedge clk);
    req_valid = 1'b1; req_sec = 1'b0; req_addr = 22'(5 * 32768); prot_set = 1'b1;
    #2 chk("R3 same-cycle request uses old state", ok_t, 1);
    @(negedge clk); prot_set = 1'b0;
    #2 chk("R3 protected sector refused", ok_t, 0);
    drive(1'b1, 1'b0, 6 * 32768);
    chk("R3 same-group sector refused", ok_t, 0);
    drive(1'b1, 1'b0, 8 * 32768);
    chk("R3 next group allowed", ok_t, 1);
  endtask

  task automatic t_temp;
    @(negedge clk); unprot_temp = 1'b1;
    drive(1'b1, 1'b0, 5 * 32768);
    chk("R7 temp unprotect allows", ok_t, 1);
    @(negedge clk); unprot_temp = 1'b0;
    drive(1'b1, 1'b0, 5 * 32768);
    chk("R7 protection returns", ok_t, 0);
  endtask

  task automatic t_clear;
    @(negedge clk);
    req_addr = 22'(20 * 32768); prot_set = 1'b1; unprot_all = 1'b1;
    @(negedge clk); prot_set = 1'b0; unprot_all = 1'b0;
    drive(1'b1, 1'b0, 5 * 32768);
    chk("R6 cleared group allowed", ok_t, 1);
    drive(1'b1, 1'b0, 20 * 32768);
    chk("R6 clear wins over set", ok_t, 1);
  endtask

  task automatic t_secure;
    @(negedge clk); sec_lock = 1'b1;
    @(negedge clk); sec_lock = 1'b0;
    drive(1'b1, 1'b1, 0);
    chk("R5 locked region refused", ok_t, 0);
    drive(1'b1, 1'b0, 0);
    chk("R5 lock leaves array", ok_t, 1);
    @(negedge clk); unprot_all = 1'b1; unprot_temp = 1'b1;
    @(negedge clk); unprot_all = 1'b0;
    drive(1'b1, 1'b1, 0);
    chk("R6 R7 lock survives unprotect", ok_t, 0);
    @(negedge clk); unprot_temp = 1'b0;
    drive(1'b0, 1'b1, 0);
    chk("R8 idle with lock", ok_t, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_map;
    t_wp;
    t_protect;
    t_temp;
    t_clear;
    t_secure;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule